// File: doc/BRIEF.md
# Macro Result Dispatch and Method Writer

This block is the write-back and output stage of a small command-macro processor. The upstream stages decode each instruction and compute a 32-bit value. This block applies one of eight result modes to that value. Depending on the mode, it writes the destination register, takes the next word from the parameter queue, loads a new method address, or sends an address/data pair to the controlled engine.

An invocation starts with a one-cycle `inv_start` pulse. The caller then pushes the macro's parameters. The first word pushed goes straight into register 1, and the remaining words wait in a FIFO for fetching result modes. The method-address register packs a 12-bit target address together with a 6-bit stride. After each send, the address advances by the stride, so a run of sends can fill consecutive or strided engine registers. When the macro finishes, `exit_chk` confirms that every parameter was consumed.

The eight general registers are read combinationally through two operand ports that feed the arithmetic stage. Register 0 always reads zero.

Top module: `macro_result_writer`

## Requirements
- R1: Register 0 reads as zero on both operand ports, and a result directed to register 0 leaves it reading zero.
- R2: After `inv_start`, the first `prm_push` word loads register 1 and does not enter the queue. The first fetch then returns the second pushed word.
- R3: The result mode is taken from `res_insn[6:4]` and the destination from `res_insn[10:8]`. Mode 1 writes the value to the destination. Mode 0 writes the next fetched parameter to the destination and discards the value. Neither mode sends anything.
- R4: Modes 2 and 5 load the method address from `res_value[11:0]` and the stride from `res_value[17:12]`. Mode 2 writes the value to the destination and mode 5 writes a fetched parameter. Neither mode sends anything.
- R5: Mode 4 writes the value to the destination and sends it. Mode 3 writes a fetched parameter to the destination and sends the value. Both send to the current method address.
- R6: Mode 6 writes the value, loads the method address from it, and sends a freshly fetched parameter to that new address. Mode 7 does the same, except that the data sent is `res_value[17:12]`, zero-extended.
- R7: After every send, the 12-bit method address advances by the stride, wrapping modulo 4096.
- R8: While `mw_valid` is high and `mw_ready` is low, `mw_addr` and `mw_data` hold steady and `res_ready` is low.
- R9: A fetch from an empty queue writes zero and sets `err_fetch`, which stays set until the next `inv_start`.
- R10: An `exit_chk` pulse sets `err_left` if parameters remain unfetched. With an empty queue, `err_left` stays low.
- R11: After reset, `mw_valid`, `err_fetch` and `err_left` are low, `res_ready` is high, and every register reads zero.
- R12: `inv_start` clears all registers, the queue, the method address and both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_start | input | 1 | Begins a new invocation |
| prm_push | input | 1 | Pushes one parameter word |
| prm_data | input | 32 | Parameter word |
| rd_a_sel | input | 3 | Operand A register index |
| rd_a_data | output | 32 | Operand A value |
| rd_b_sel | input | 3 | Operand B register index |
| rd_b_data | output | 32 | Operand B value |
| res_valid | input | 1 | Result offered |
| res_ready | output | 1 | Result accepted this cycle |
| res_insn | input | 32 | Instruction word carrying mode and destination |
| res_value | input | 32 | Computed value |
| mw_valid | output | 1 | Engine write pending |
| mw_ready | input | 1 | Engine accepts the write |
| mw_addr | output | 12 | Engine register address |
| mw_data | output | 32 | Engine write data |
| exit_chk | input | 1 | Macro end, checks for unconsumed parameters |
| err_fetch | output | 1 | Sticky flag: fetch from an empty queue |
| err_left | output | 1 | Sticky flag: parameters left at exit |

## Verification
The assertions assume that `inv_start` never coincides with an accepted result, and that it arrives only once the engine port has drained. They also assume the caller never pushes into a full queue. The bench keeps within these limits: it pulses start only while `mw_valid` is low and pushes at most five words into a sixteen-entry queue. It also holds `res_valid` only for a single accepted cycle, so every accepted result maps to exactly one expected table row.

// File: rtl/macro_result_writer.sv
module macro_result_writer #(
  parameter int DW = 32,
  parameter int NREG = 8,
  parameter int PQ_DEPTH = 16,
  parameter int MA_W = 12,
  parameter int INC_W = 6,
  localparam int RW = $clog2(NREG),
  localparam int QW = $clog2(PQ_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inv_start,
  input  logic          prm_push,
  input  logic [DW-1:0] prm_data,
  input  logic [RW-1:0] rd_a_sel,
  output logic [DW-1:0] rd_a_data,
  input  logic [RW-1:0] rd_b_sel,
  output logic [DW-1:0] rd_b_data,
  input  logic          res_valid,
  output logic          res_ready,
  input  logic [31:0]   res_insn,
  input  logic [DW-1:0] res_value,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [MA_W-1:0] mw_addr,
  output logic [DW-1:0] mw_data,
  input  logic          exit_chk,
  output logic          err_fetch,
  output logic          err_left
);
  localparam logic [QW:0] QFULL = PQ_DEPTH[QW:0];

  logic [DW-1:0]    regs [NREG];
  logic [DW-1:0]    pq [PQ_DEPTH];
  logic [QW-1:0]    rptr, wptr;
  logic [QW:0]      cnt;
  logic             first_pend;
  logic [MA_W-1:0]  ma_addr;
  logic [INC_W-1:0] ma_inc;

  logic [2:0]    mode;
  logic [RW-1:0] dst;
  logic fire, uses_fetch, loads_fetch, sets_ma, sends, q_empty, pop, push_ok;
  logic [DW-1:0]    fetch_val, wr_val, snd_data;
  logic [MA_W-1:0]  base_addr;
  logic [INC_W-1:0] base_inc;

  assign mode = res_insn[6:4];
  assign dst  = res_insn[8 +: RW];

  assign rd_a_data = (rd_a_sel == '0) ? '0 : regs[rd_a_sel];
  assign rd_b_data = (rd_b_sel == '0) ? '0 : regs[rd_b_sel];

  assign res_ready = !mw_valid || mw_ready;
  assign fire      = res_valid && res_ready;

  assign loads_fetch = (mode == 3'd0) || (mode == 3'd3) || (mode == 3'd5);
  assign uses_fetch  = loads_fetch || (mode == 3'd6);
  assign sets_ma     = (mode == 3'd2) || (mode >= 3'd5);
  assign sends       = (mode == 3'd3) || (mode == 3'd4) || (mode >= 3'd6);

  assign q_empty   = (cnt == '0);
  assign fetch_val = q_empty ? '0 : pq[rptr];
  assign pop       = fire && uses_fetch && !q_empty;
  assign push_ok   = prm_push && !first_pend && (cnt != QFULL);

  assign wr_val = loads_fetch ? fetch_val : res_value;

  always_comb begin
    case (mode)
      3'd6:    snd_data = fetch_val;
      3'd7:    snd_data = {{(DW-INC_W){1'b0}}, res_value[MA_W +: INC_W]};
      default: snd_data = res_value;
    endcase
  end

  assign base_addr = sets_ma ? res_value[MA_W-1:0] : ma_addr;
  assign base_inc  = sets_ma ? res_value[MA_W +: INC_W] : ma_inc;

  always_ff @(posedge clk) begin
    if (!rst_n || inv_start) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      rptr       <= '0;
      wptr       <= '0;
      cnt        <= '0;
      first_pend <= 1'b1;
      ma_addr    <= '0;
      ma_inc     <= '0;
      err_fetch  <= 1'b0;
      err_left   <= 1'b0;
    end else begin
      if (prm_push && first_pend) begin
        regs[1]    <= prm_data;
        first_pend <= 1'b0;
      end
      if (push_ok) begin
        pq[wptr] <= prm_data;
        wptr     <= wptr + 1'b1;
      end
      if (pop) rptr <= rptr + 1'b1;
      cnt <= cnt + {{QW{1'b0}}, push_ok} - {{QW{1'b0}}, pop};
      if (fire) begin
        if (dst != '0) regs[dst] <= wr_val;
        if (uses_fetch && q_empty) err_fetch <= 1'b1;
        ma_inc  <= base_inc;
        ma_addr <= sends ? base_addr + {{(MA_W-INC_W){1'b0}}, base_inc} : base_addr;
      end
      if (exit_chk && !q_empty) err_left <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mw_valid <= 1'b0;
      mw_addr  <= '0;
      mw_data  <= '0;
    end else if (fire && sends) begin
      mw_valid <= 1'b1;
      mw_addr  <= base_addr;
      mw_data  <= snd_data;
    end else if (mw_ready) begin
      mw_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mrw_checker.sv
module mrw_checker #(
  parameter int DW = 32,
  parameter int RW = 3,
  parameter int MA_W = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inv_start,
  input logic [RW-1:0] rd_a_sel,
  input logic [DW-1:0] rd_a_data,
  input logic [RW-1:0] rd_b_sel,
  input logic [DW-1:0] rd_b_data,
  input logic          res_valid,
  input logic          res_ready,
  input logic [31:0]   res_insn,
  input logic          mw_valid,
  input logic          mw_ready,
  input logic [MA_W-1:0] mw_addr,
  input logic [DW-1:0] mw_data,
  input logic          err_fetch,
  input logic          err_left
);
  logic [2:0] m;
  logic acc;
  assign m = res_insn[6:4];
  assign acc = res_valid && res_ready;

  AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_sel == '0) |-> (rd_a_data == '0)); // R1
  AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_sel == '0) |-> (rd_b_data == '0)); // R1
  AST_SEND_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (m == 3'd3 || m == 3'd4 || m >= 3'd6)) |=> mw_valid); // R5
  AST_NO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !mw_valid && (m <= 3'd2 || m == 3'd5)) |=> !mw_valid); // R3
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data))); // R8
  AST_FETCH_ERR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_fetch && !inv_start) |=> err_fetch); // R9
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    inv_start |=> (!err_fetch && !err_left)); // R12
endmodule

bind macro_result_writer mrw_checker #(.DW(DW), .RW(RW), .MA_W(MA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inv_start(inv_start),
  .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data), .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
  .res_valid(res_valid), .res_ready(res_ready), .res_insn(res_insn),
  .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
  .err_fetch(err_fetch), .err_left(err_left)
);

// File: tb/tb_macro_result_writer.sv
module tb_macro_result_writer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic inv_start = 0, prm_push = 0, res_valid = 0, mw_ready = 1, exit_chk = 0;
  logic [31:0] prm_data = 0, res_insn = 0, res_value = 0;
  logic [2:0] rd_a_sel = 0, rd_b_sel = 0;
  logic [31:0] rd_a_data, rd_b_data, mw_data;
  logic [11:0] mw_addr;
  logic res_ready, mw_valid, err_fetch, err_left;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  macro_result_writer dut (.*);

  // {mode3, dst3, value32, send1, addr12, data32, reg32}
  localparam int NV = 11;
  localparam logic [114:0] TAB [NV] = '{
    {3'd2, 3'd2, 32'h0000_3010, 1'b0, 12'h000, 32'h0,     32'h0000_3010},
    {3'd4, 3'd3, 32'h0000_AAAA, 1'b1, 12'h010, 32'hAAAA,  32'h0000_AAAA},
    {3'd3, 3'd4, 32'h0000_BBBB, 1'b1, 12'h013, 32'hBBBB,  32'h0000_0022},
    {3'd0, 3'd5, 32'h0000_DEAD, 1'b0, 12'h000, 32'h0,     32'h0000_0033},
    {3'd1, 3'd6, 32'h0000_1234, 1'b0, 12'h000, 32'h0,     32'h0000_1234},
    {3'd5, 3'd7, 32'h0001_0FFE, 1'b0, 12'h000, 32'h0,     32'h0000_0044},
    {3'd4, 3'd0, 32'h0000_0077, 1'b1, 12'hFFE, 32'h77,    32'h0},
    {3'd4, 3'd2, 32'h0000_0088, 1'b1, 12'h00E, 32'h88,    32'h0000_0088},
    {3'd6, 3'd3, 32'h0002_1100, 1'b1, 12'h100, 32'h55,    32'h0002_1100},
    {3'd7, 3'd4, 32'h0003_F200, 1'b1, 12'h200, 32'h3F,    32'h0003_F200},
    {3'd4, 3'd5, 32'h0000_0099, 1'b1, 12'h23F, 32'h99,    32'h0000_0099}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); inv_start = 1;
    @(negedge clk); inv_start = 0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); prm_push = 1; prm_data = d;
    @(negedge clk); prm_push = 0;
  endtask

  task automatic result(input logic [2:0] md, input logic [2:0] ds, input logic [31:0] v);
    @(negedge clk);
    res_valid = 1; res_insn = {21'd0, ds, 1'b0, md, 4'd0}; res_value = v;
    @(negedge clk);
    res_valid = 0;
  endtask

  function automatic logic [31:0] rreg(input logic [2:0] s);
    rd_a_sel = s;
    return 32'h0;
  endfunction

  task automatic read_reg(input logic [2:0] s, output logic [31:0] v);
    rd_a_sel = s; #1; v = rd_a_data;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 mw_valid", {31'd0, mw_valid}, 32'd0);
    chk("R11 res_ready", {31'd0, res_ready}, 32'd1);
    chk("R11 errors", {30'd0, err_fetch, err_left}, 32'd0);
    read_reg(3'd3, v); chk("R11 reg3", v, 32'd0);

    pulse_start();
    push(32'h11); push(32'h22); push(32'h33); push(32'h44); push(32'h55);
    read_reg(3'd1, v); chk("R2 reg1 first param", v, 32'h11);
    rd_b_sel = 3'd0; #1; chk("R1 port b zero", rd_b_data, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [114:0] e;
      e = TAB[i];
      result(e[114:112], e[111:109], e[108:77]);
      chk($sformatf("R3-R7 row%0d send", i), {31'd0, mw_valid}, {31'd0, e[76]});
      if (e[76]) begin
        chk($sformatf("R7 row%0d addr", i), {20'd0, mw_addr}, {20'd0, e[75:64]});
        chk($sformatf("R5 R6 row%0d data", i), mw_data, e[63:32]);
      end
      read_reg(e[111:109], v);
      chk($sformatf("R1 R3 R4 row%0d reg", i), v, e[31:0]);
    end
    chk("R9 no error yet", {31'd0, err_fetch}, 32'd0);

    @(negedge clk); exit_chk = 1; @(negedge clk); exit_chk = 0;
    chk("R10 queue drained", {31'd0, err_left}, 32'd0);

    result(3'd0, 3'd1, 32'h5A5A);
    chk("R9 err_fetch set", {31'd0, err_fetch}, 32'd1);
    read_reg(3'd1, v); chk("R9 empty fetch loads zero", v, 32'd0);

    // R8 stall
    mw_ready = 0;
    result(3'd4, 3'd6, 32'hC0);
    chk("R8 pending addr", {20'd0, mw_addr}, 32'h27E);
    repeat (3) @(negedge clk);
    chk("R8 held valid", {31'd0, mw_valid}, 32'd1);
    chk("R8 held data", mw_data, 32'hC0);
    chk("R8 res_ready low", {31'd0, res_ready}, 32'd0);
    chk("R9 sticky", {31'd0, err_fetch}, 32'd1);
    mw_ready = 1;
    @(negedge clk);
    chk("R8 drained", {31'd0, mw_valid}, 32'd0);

    // R12 and R2 on a new invocation
    pulse_start();
    chk("R12 err cleared", {31'd0, err_fetch}, 32'd0);
    read_reg(3'd6, v); chk("R12 reg6 cleared", v, 32'd0);
    read_reg(3'd1, v); chk("R12 reg1 cleared", v, 32'd0);
    push(32'hA1); push(32'hA2); push(32'hA3);
    read_reg(3'd1, v); chk("R2 reg1 new first", v, 32'hA1);
    result(3'd0, 3'd2, 32'hFFFF);
    read_reg(3'd2, v); chk("R2 fetch returns second", v, 32'hA2);
    chk("R3 mode0 no send", {31'd0, mw_valid}, 32'd0);
    @(negedge clk); exit_chk = 1; @(negedge clk); exit_chk = 0;
    chk("R10 leftover flagged", {31'd0, err_left}, 32'd1);

    done = 1;
    finish_run();
  end
endmodule